// File: doc/BRIEF.md
# Split Up/Down Modulo-6 Ring Sequencer

This block steps a position around a ring of six places, 0 through 5. An up command moves it one place forward and wraps from 5 to 0. A down command moves it one place back and wraps from 0 to 5. A cycle with no command leaves it where it is. The sequencer is not one six-state machine. It is built as two identical four-state machines. The lower half covers positions 0 to 2 and the upper half covers positions 3 to 5. Each half also has a parked (idle) state that it sits in while the other half holds the position.

A half gives up control at the edge of its range. Stepping forward past its last position, or back past its first, sends it to its parked state. In the same clock edge, the parked half reads that its peer sits at the matching boundary and takes over at the correct end of its own range. A parked half stays parked while none of its wake-up conditions holds. The only signals that cross between the halves are two boundary flags from each half. The block reports the combined position as a 3-bit index, together with the raw local state of both halves.

The command inputs are plain per-cycle control levels with no handshake. Whatever is present at a rising clock edge is acted on at that edge.

Top module: `ring6_split_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) leaves the lower half at local code 0, the upper half parked (code 3) and `pos_idx` at 0.
- R2: Local code encoding in each half: codes 0, 1 and 2 are working positions, and code 3 is parked. Lower-half code k means position k. Upper-half code k means position 3+k. `pos_idx` equals the position of whichever half is working.
- R3: At every cycle exactly one half is working and the other is parked.
- R4: With `up_cmd` high, `pos_idx` advances by one after the edge, wrapping from 5 to 0.
- R5: With only `dn_cmd` high, `pos_idx` goes back by one after the edge, wrapping from 0 to 5.
- R6: With both commands low, both local states and `pos_idx` stay unchanged.
- R7: With both commands high, the block behaves exactly as for `up_cmd` alone.
- R8: Forward handoff: a half at its code 2 under an up step parks, and the other half leaves parked for its code 0 in the same edge.
- R9: Backward handoff: a half at its code 0 under a down step parks, and the other half leaves parked for its code 2 in the same edge.
- R10: A parked half keeps code 3 whenever its peer is not at the boundary matching the applied step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| up_cmd | input | 1 | Step forward this cycle; wins over `dn_cmd` |
| dn_cmd | input | 1 | Step backward this cycle |
| pos_idx | output | 3 | Combined ring position, 0 to 5 |
| lo_state | output | 2 | Local code of the lower half (3 = parked) |
| hi_state | output | 2 | Local code of the upper half (3 = parked) |

## Verification
The sweep starts from every one of the six positions under each of the four command combinations, so every boundary handoff in both directions is hit directly. A design with a wrong wake-up qualifier would leave both halves parked or both working. One that skipped the wrap would step to index 6 or 7 instead. A long pseudo-random command run is then compared cycle by cycle against a plain modulo-6 counter. This catches halves that disagree when both commands are high, which shows up as a skipped or doubled position. It also catches a parked half that wakes on the wrong boundary. Resets applied from every position confirm that no stale state survives.

// File: rtl/ring6_pkg.sv
package ring6_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_FWD  = 2'd1,
    CMD_BACK = 2'd2
  } step_cmd_t;

  function automatic int local_width(input int n_work);
    return $clog2(n_work + 1);
  endfunction

  function automatic int index_width(input int n_work);
    return $clog2(2 * n_work);
  endfunction
endpackage

// File: rtl/ring6_half.sv
module ring6_half
  import ring6_pkg::*;
#(
  parameter int LOCAL_N      = 3,
  parameter bit START_ACTIVE = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  step_cmd_t                     cmd,
  input  logic                          peer_last,
  input  logic                          peer_first,
  output logic [local_width(LOCAL_N)-1:0] state,
  output logic                          at_last,
  output logic                          at_first
);
  localparam int LW = local_width(LOCAL_N);
  localparam logic [LW-1:0] PARK = LW'(LOCAL_N);
  localparam logic [LW-1:0] LAST = LW'(LOCAL_N - 1);
  localparam logic [LW-1:0] ONE  = LW'(1);

  logic [LW-1:0] nxt;

  always_comb begin
    nxt = state;
    if (state == PARK) begin
      // wake only when the peer is leaving through the matching edge
      if (cmd == CMD_FWD && peer_last)       nxt = '0;
      else if (cmd == CMD_BACK && peer_first) nxt = LAST;
    end else begin
      unique case (cmd)
        CMD_FWD:  nxt = (state == LAST) ? PARK : state + ONE;
        CMD_BACK: nxt = (state == '0)   ? PARK : state - ONE;
        default:  nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= START_ACTIVE ? '0 : PARK;
    else     state <= nxt;
  end

  assign at_last  = (state == LAST);
  assign at_first = (state == '0);
endmodule

// File: rtl/ring6_index.sv
module ring6_index
  import ring6_pkg::*;
#(
  parameter int LOCAL_N = 3
) (
  input  logic [local_width(LOCAL_N)-1:0] lo_code,
  input  logic [local_width(LOCAL_N)-1:0] hi_code,
  output logic [index_width(LOCAL_N)-1:0] idx
);
  localparam int LW = local_width(LOCAL_N);
  localparam int IW = index_width(LOCAL_N);
  localparam logic [LW-1:0] PARK = LW'(LOCAL_N);

  always_comb begin
    if (lo_code != PARK) idx = IW'(lo_code);
    else                 idx = IW'(LOCAL_N) + IW'(hi_code);
  end
endmodule

// File: rtl/ring6_split_seq.sv
module ring6_split_seq
  import ring6_pkg::*;
#(
  parameter int LOCAL_N = 3
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    up_cmd,
  input  logic                                    dn_cmd,
  output logic [ring6_pkg::index_width(LOCAL_N)-1:0] pos_idx,
  output logic [ring6_pkg::local_width(LOCAL_N)-1:0] lo_state,
  output logic [ring6_pkg::local_width(LOCAL_N)-1:0] hi_state
);
  localparam int LW = local_width(LOCAL_N);

  step_cmd_t cmd;
  logic [LW-1:0] code   [2];
  logic          last_f [2];
  logic          first_f[2];

  // forward wins so both halves always see the same single command
  always_comb begin
    if (up_cmd)      cmd = CMD_FWD;
    else if (dn_cmd) cmd = CMD_BACK;
    else             cmd = CMD_HOLD;
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    ring6_half #(
      .LOCAL_N     (LOCAL_N),
      .START_ACTIVE(h == 0)
    ) u_half (
      .clk       (clk),
      .rst       (rst),
      .cmd       (cmd),
      .peer_last (last_f[1-h]),
      .peer_first(first_f[1-h]),
      .state     (code[h]),
      .at_last   (last_f[h]),
      .at_first  (first_f[h])
    );
  end

  assign lo_state = code[0];
  assign hi_state = code[1];

  ring6_index #(.LOCAL_N(LOCAL_N)) u_index (
    .lo_code(code[0]),
    .hi_code(code[1]),
    .idx    (pos_idx)
  );
endmodule

// File: rtl/ring6_split_seq_chk.sv
module ring6_split_seq_chk
  import ring6_pkg::*;
#(
  parameter int LOCAL_N = 3
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          up_cmd,
  input logic                          dn_cmd,
  input logic [index_width(LOCAL_N)-1:0] pos_idx,
  input logic [local_width(LOCAL_N)-1:0] lo_state,
  input logic [local_width(LOCAL_N)-1:0] hi_state
);
  localparam int LW = local_width(LOCAL_N);
  localparam int IW = index_width(LOCAL_N);
  localparam logic [LW-1:0] PARK = LW'(LOCAL_N);
  localparam logic [LW-1:0] LAST = LW'(LOCAL_N - 1);
  localparam logic [IW-1:0] TOP  = IW'(2 * LOCAL_N - 1);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (lo_state == '0 && hi_state == PARK));

  assert_not_both_parked_R3: assert property (@(posedge clk) disable iff (rst)
    !(lo_state == PARK && hi_state == PARK));

  assert_not_both_working_R3: assert property (@(posedge clk) disable iff (rst)
    !(lo_state != PARK && hi_state != PARK));

  assert_fwd_step_R4: assert property (@(posedge clk) disable iff (rst)
    up_cmd |=> pos_idx == (($past(pos_idx) == TOP) ? '0 : $past(pos_idx) + IW'(1)));

  assert_back_step_R5: assert property (@(posedge clk) disable iff (rst)
    (dn_cmd && !up_cmd) |=> pos_idx == (($past(pos_idx) == '0) ? TOP : $past(pos_idx) - IW'(1)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!up_cmd && !dn_cmd) |=> ($stable(lo_state) && $stable(hi_state)));

  assert_fwd_handoff_R8: assert property (@(posedge clk) disable iff (rst)
    (up_cmd && lo_state == LAST) |=> (lo_state == PARK && hi_state == '0));

  assert_back_handoff_R9: assert property (@(posedge clk) disable iff (rst)
    (dn_cmd && !up_cmd && hi_state == '0) |=> (hi_state == PARK && lo_state == LAST));
endmodule

bind ring6_split_seq ring6_split_seq_chk #(.LOCAL_N(LOCAL_N)) u_chk (.*);

// File: tb/test_ring6_split_seq.sv
module test_ring6_split_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_cmd = 1'b0;
  logic dn_cmd = 1'b0;
  logic [2:0] pos_idx;
  logic [1:0] lo_state, hi_state;

  int n_checks = 0;
  int n_fail   = 0;
  int model    = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  ring6_split_seq i_ring6_split_seq (
    .clk(clk), .rst(rst), .up_cmd(up_cmd), .dn_cmd(dn_cmd),
    .pos_idx(pos_idx), .lo_state(lo_state), .hi_state(hi_state)
  );

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d (time %0t)", req, got, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    int ea = (model < 3) ? model : 3;
    int eb = (model >= 3) ? model - 3 : 3;
    check(tag, int'(pos_idx), model);
    check("R2 lower code", int'(lo_state), ea);
    check("R2 upper code", int'(hi_state), eb);
    check("R3 one working", int'((lo_state == 2'd3) + (hi_state == 2'd3)), 1);
    if (model < 3) check("R10 upper parked", int'(hi_state), 3);
    else           check("R10 lower parked", int'(lo_state), 3);
  endtask

  task automatic do_reset();
    rst = 1'b1; up_cmd = 1'b0; dn_cmd = 1'b0;
    @(posedge clk); #2;
    rst = 1'b0;
    model = 0;
    check_all("R1 reset");
  endtask

  task automatic step(input bit u, input bit d, input string tag);
    up_cmd = u; dn_cmd = d;
    @(posedge clk); #2;
    if (u)      model = (model + 1) % 6;
    else if (d) model = (model + 5) % 6;
    check_all(tag);
  endtask

  initial begin
    #2;
    do_reset();
    // sweep: every start position x every command combination
    for (int p = 0; p < 6; p++) begin
      for (int c = 0; c < 4; c++) begin
        string tag;
        bit u = c[0];
        bit d = c[1];
        do_reset();
        for (int k = 0; k < p; k++) step(1'b1, 1'b0, "R4 walk");
        if (!u && !d)       tag = "R6 hold";
        else if (u && d)    tag = "R7 both";
        else if (u && (p == 2 || p == 5)) tag = "R8 fwd handoff";
        else if (u)         tag = "R4 fwd";
        else if (p == 0 || p == 3) tag = "R9 back handoff";
        else                tag = "R5 back";
        step(u, d, tag);
      end
    end
    // full backward lap from reset, covering the 0 -> 5 wrap
    do_reset();
    for (int k = 0; k < 7; k++) step(1'b0, 1'b1, "R5 lap");
    // pseudo-random run against the plain modulo-6 model
    do_reset();
    begin
      int unsigned lfsr = 32'h1ACE_B00C;
      for (int k = 0; k < 3000; k++) begin
        lfsr = lfsr * 32'd1664525 + 32'd1013904223;
        if (lfsr[31:28] == 4'h0) begin
          do_reset();
        end else begin
          step(lfsr[20], lfsr[13], "R4/R5/R7 random");
        end
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule